// File: doc/BRIEF.md
# Epoch-Based Coherence Monitor

This block watches a multi-core memory system at run time and reports breaches of coherence. It does not track per-line protocol states. Each core reports, on its own event port, when it gains or gives up permission on a cache block. A permission interval is read-only or read-write. Each core also reports every load and store it performs, with the data value. From these events the monitor decides three things: whether each access fell inside a permission interval that allows it, whether a writer's interval overlapped anyone else's on the same block, and whether each new interval saw the value left behind by the last writer.

The monitor keeps a small tag-matched table of block addresses. Each entry records which cores hold read-only or read-write permission, the block's committed value, and the last value stored during the current write interval. The three error classes have separate sticky flags. Each flag latches the core index and block address of its first offence, so a debug flow can read the first failure after a long run. Events that arrive from several cores in one cycle are applied one after another in ascending core order, as if they had happened in that order.

Top module: `coh_epoch_checker`

## Requirements
- R1: A load (kind code 3) is legal only when the issuing core holds a read-only or read-write interval on that block. Otherwise `acc_err` is set.
- R2: A store (kind code 4) is legal only when the issuing core holds a read-write interval on that block. A store inside a read-only interval, or outside any interval, sets `acc_err`.
- R3: Opening a read-write interval (kind 1) while another core holds any interval on the block sets `ovl_err`. Opening a read-only interval (kind 0) while another core holds a read-write interval sets `ovl_err`. Two read-only holders are legal.
- R4: The `ev_data` reported with an interval open must equal the block's committed value, or `dat_err` is set. When a read-write interval closes (kind 2), the last value stored in it becomes the committed value. A read-write interval closed without a store leaves the committed value unchanged.
- R5: A block with no reference value yet takes the data of its first interval open as its reference, and no data check is made on that open.
- R6: A close (kind 2) by a core holding no interval on the block sets `acc_err`, and so does a close on an untracked block. An open by a core that already holds an interval on that block also sets `acc_err` and leaves the table unchanged.
- R7: Events reported in the same cycle are applied in ascending core-index order. A later core sees the effect of an earlier core's event in that cycle.
- R8: Each error flag is sticky until reset. With its flag it latches the core index and block address of the first offending event, and it holds them afterwards. When several cores offend in the first cycle, the lowest core index is latched.
- R9: A table entry is free when it is unused or no core holds an interval on it. An open on an untracked block takes the lowest-index free entry, dropping that entry's old block. If no entry is free, the sticky `ovf_flag` is set and the event is not checked.
- R10: After a synchronous active-low reset, all flags, latched cores and latched addresses are zero and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_valid | input | NC | One valid bit per core event port |
| ev_kind | input | 3*NC | Per-core event kind: 0 open read-only, 1 open read-write, 2 close, 3 load, 4 store |
| ev_addr | input | AW*NC | Per-core block address |
| ev_data | input | DW*NC | Per-core data: observed value on open, value on load or store |
| acc_err | output | 1 | Sticky illegal-access flag |
| acc_core | output | CW | Core index of first illegal access |
| acc_addr | output | AW | Block address of first illegal access |
| ovl_err | output | 1 | Sticky interval-overlap flag |
| ovl_core | output | CW | Core index of first overlap |
| ovl_addr | output | AW | Block address of first overlap |
| dat_err | output | 1 | Sticky data-mismatch flag |
| dat_core | output | CW | Core index of first mismatch |
| dat_addr | output | AW | Block address of first mismatch |
| ovf_flag | output | 1 | Sticky table-overflow flag |

## Verification
Directed sequences compare a write interval that ends after several stores with one that ends with none. This shows whether the last store or the old value is committed. Same-cycle pairs are sent in both core orders: the close-then-open order must be clean, and the open-then-close order must report an overlap. Together they show whether events are applied in index order. A fill of every table entry followed by a release tells overflow apart from eviction. Long pseudo-random streams over a few more addresses than the table holds, with small data values, exercise legal reuse and mismatch together. A behavioural model checks these streams on every cycle.

// File: rtl/coh_chk_pkg.sv
// Shared encodings for the epoch coherence monitor.
// Assumes every module that imports it uses the same kind width.
package coh_chk_pkg;
    localparam int KIND_W = 3;
    localparam int N_ERR  = 3;
    localparam int ERR_ACC = 0;
    localparam int ERR_OVL = 1;
    localparam int ERR_DAT = 2;

    typedef enum logic [KIND_W-1:0] {
        EV_OPEN_RO = 3'd0,
        EV_OPEN_RW = 3'd1,
        EV_CLOSE   = 3'd2,
        EV_LOAD    = 3'd3,
        EV_STORE   = 3'd4
    } ev_kind_e;
endpackage

// File: rtl/coh_match.sv
// Tag lookup and free-slot search over the block table.
// Assumes the caller supplies flattened tags; the lowest index wins in both searches.
module coh_match #(
    parameter int NB = 8,
    parameter int AW = 16,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB-1:0]         vld,
    input  logic [NB-1:0]         idle,
    input  logic [NB-1:0][AW-1:0] tags,
    input  logic [AW-1:0]         addr,
    output logic                  hit,
    output logic [IW-1:0]         hit_idx,
    output logic                  free_ok,
    output logic [IW-1:0]         free_idx
);
    // Find the lowest valid entry whose tag equals the address.
    always_comb begin : p_hit
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (vld[i] && tags[i] == addr) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    // Find the lowest entry that is unused or has no open interval.
    always_comb begin : p_free
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (!vld[i] || idle[i]) begin
                free_ok  = 1'b1;
                free_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/coh_step.sv
// Applies one core's event to a copy of the block table and reports the errors it causes.
// Assumes instances are chained in core order so later cores see earlier updates.
module coh_step
    import coh_chk_pkg::*;
#(
    parameter int NC   = 4,
    parameter int NB   = 8,
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int CORE = 0,
    localparam int EW  = 2 * DW + 2 * NC + AW + 3,
    localparam int IW  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                  en,
    input  logic [KIND_W-1:0]     kind,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         data,
    input  logic [NB-1:0][EW-1:0] tbl_i,
    output logic [NB-1:0][EW-1:0] tbl_o,
    output logic                  f_acc,
    output logic                  f_ovl,
    output logic                  f_dat,
    output logic                  f_ovf
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] tag;
        logic [NC-1:0] ro;
        logic [NC-1:0] rw;
        logic [DW-1:0] cval;
        logic          has_ref;
        logic [DW-1:0] sval;
        logic          sflg;
    } ent_t;

    localparam logic [NC-1:0] ME = NC'(1) << CORE;

    ent_t                  cur [NB];
    ent_t                  t   [NB];
    ent_t                  e;
    logic [NB-1:0]         vld_v;
    logic [NB-1:0]         idle_v;
    logic [NB-1:0][AW-1:0] tag_v;
    logic                  hit;
    logic [IW-1:0]         hit_idx;
    logic                  free_ok;
    logic [IW-1:0]         free_idx;
    logic [IW-1:0]         idx;
    logic                  go;

    // Unpack the incoming table and derive the lookup keys.
    always_comb begin : p_unpack
        for (int i = 0; i < NB; i++) begin
            cur[i]    = tbl_i[i];
            vld_v[i]  = cur[i].vld;
            idle_v[i] = (cur[i].ro | cur[i].rw) == '0;
            tag_v[i]  = cur[i].tag;
        end
    end

    coh_match #(.NB(NB), .AW(AW)) u_match (
        .vld      (vld_v),
        .idle     (idle_v),
        .tags     (tag_v),
        .addr     (addr),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .free_ok  (free_ok),
        .free_idx (free_idx)
    );

    // Apply the event: legality, overlap and value checks, then the table update.
    always_comb begin : p_apply
        for (int i = 0; i < NB; i++) t[i] = cur[i];
        f_acc = 1'b0;
        f_ovl = 1'b0;
        f_dat = 1'b0;
        f_ovf = 1'b0;
        idx   = hit_idx;
        go    = 1'b0;
        e     = '0;
        if (en) begin
            case (ev_kind_e'(kind))
                EV_OPEN_RO, EV_OPEN_RW: begin
                    go = 1'b1;
                    if (!hit) begin
                        if (free_ok) begin
                            idx        = free_idx;
                            t[idx]     = '0;
                            t[idx].vld = 1'b1;
                            t[idx].tag = addr;
                        end else begin
                            f_ovf = 1'b1;
                            go    = 1'b0;
                        end
                    end
                    if (go) begin
                        e = t[idx];
                        if (((e.ro | e.rw) & ME) != '0) begin
                            f_acc = 1'b1;
                        end else begin
                            if (ev_kind_e'(kind) == EV_OPEN_RW)
                                f_ovl = |((e.ro | e.rw) & ~ME);
                            else
                                f_ovl = |(e.rw & ~ME);
                            if (e.has_ref) begin
                                f_dat = (e.cval != data);
                            end else begin
                                e.cval    = data;
                                e.has_ref = 1'b1;
                            end
                            if (ev_kind_e'(kind) == EV_OPEN_RW) begin
                                e.rw   = e.rw | ME;
                                e.sflg = 1'b0;
                            end else begin
                                e.ro = e.ro | ME;
                            end
                        end
                        t[idx] = e;
                    end
                end
                EV_CLOSE: begin
                    if (!hit) begin
                        f_acc = 1'b1;
                    end else begin
                        e = t[idx];
                        if ((e.rw & ME) != '0) begin
                            if (e.sflg) e.cval = e.sval;
                            e.sflg = 1'b0;
                            e.rw   = e.rw & ~ME;
                        end else if ((e.ro & ME) != '0) begin
                            e.ro = e.ro & ~ME;
                        end else begin
                            f_acc = 1'b1;
                        end
                        t[idx] = e;
                    end
                end
                EV_LOAD: begin
                    if (!hit || ((t[idx].ro | t[idx].rw) & ME) == '0) f_acc = 1'b1;
                end
                EV_STORE: begin
                    if (!hit || (t[idx].rw & ME) == '0) begin
                        f_acc = 1'b1;
                    end else begin
                        t[idx].sval = data;
                        t[idx].sflg = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        for (int i = 0; i < NB; i++) tbl_o[i] = t[i];
    end
endmodule

// File: rtl/coh_errlog.sv
// Sticky first-offence log for one error class.
// Assumes hit bits arrive already ordered by core index; the lowest index is kept.
module coh_errlog #(
    parameter int NC = 4,
    parameter int AW = 16,
    localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NC-1:0]         hits,
    input  logic [NC-1:0][AW-1:0] addrs,
    output logic                  err,
    output logic [CW-1:0]         core,
    output logic [AW-1:0]         addr
);
    logic [CW-1:0] first;

    // Pick the lowest-index core that offended this cycle.
    always_comb begin : p_first
        first = '0;
        for (int i = NC - 1; i >= 0; i--) begin
            if (hits[i]) first = CW'(i);
        end
    end

    // Latch the first offence and hold it until reset.
    always_ff @(posedge clk) begin : p_latch
        if (!rst_n) begin
            err  <= 1'b0;
            core <= '0;
            addr <= '0;
        end else if (!err && |hits) begin
            err  <= 1'b1;
            core <= first;
            addr <= addrs[first];
        end
    end
endmodule

// File: rtl/coh_epoch_checker.sv
// Run-time coherence monitor built on read-only / read-write permission intervals.
// Assumes one event per core per cycle; same-cycle events are applied in core order.
module coh_epoch_checker
    import coh_chk_pkg::*;
#(
    parameter int NC = 4,
    parameter int NB = 8,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int CW = (NC > 1) ? $clog2(NC) : 1,
    localparam int EW = 2 * DW + 2 * NC + AW + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NC-1:0]        ev_valid,
    input  logic [NC*KIND_W-1:0] ev_kind,
    input  logic [NC*AW-1:0]     ev_addr,
    input  logic [NC*DW-1:0]     ev_data,
    output logic                 acc_err,
    output logic [CW-1:0]        acc_core,
    output logic [AW-1:0]        acc_addr,
    output logic                 ovl_err,
    output logic [CW-1:0]        ovl_core,
    output logic [AW-1:0]        ovl_addr,
    output logic                 dat_err,
    output logic [CW-1:0]        dat_core,
    output logic [AW-1:0]        dat_addr,
    output logic                 ovf_flag
);
    logic [NB-1:0][EW-1:0]      tbl_q;
    logic [NC:0][NB-1:0][EW-1:0] chain;
    logic [N_ERR-1:0][NC-1:0]   fl;
    logic [NC-1:0]              fl_ovf;
    logic [NC-1:0][AW-1:0]      addr_c;
    logic [N_ERR-1:0]           err_v;
    logic [N_ERR-1:0][CW-1:0]   core_v;
    logic [N_ERR-1:0][AW-1:0]   addr_v;

    assign chain[0] = tbl_q;
    assign addr_c   = ev_addr;

    for (genvar c = 0; c < NC; c++) begin : g_step
        coh_step #(.NC(NC), .NB(NB), .AW(AW), .DW(DW), .CORE(c)) u_step (
            .en    (ev_valid[c]),
            .kind  (ev_kind[c*KIND_W +: KIND_W]),
            .addr  (ev_addr[c*AW +: AW]),
            .data  (ev_data[c*DW +: DW]),
            .tbl_i (chain[c]),
            .tbl_o (chain[c+1]),
            .f_acc (fl[ERR_ACC][c]),
            .f_ovl (fl[ERR_OVL][c]),
            .f_dat (fl[ERR_DAT][c]),
            .f_ovf (fl_ovf[c])
        );
    end

    for (genvar g = 0; g < N_ERR; g++) begin : g_log
        coh_errlog #(.NC(NC), .AW(AW)) u_log (
            .clk   (clk),
            .rst_n (rst_n),
            .hits  (fl[g]),
            .addrs (addr_c),
            .err   (err_v[g]),
            .core  (core_v[g]),
            .addr  (addr_v[g])
        );
    end

    // Register the table after all of this cycle's events have been applied.
    always_ff @(posedge clk) begin : p_table
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= chain[NC];
    end

    // Hold the overflow indication until reset.
    always_ff @(posedge clk) begin : p_ovf
        if (!rst_n) ovf_flag <= 1'b0;
        else        ovf_flag <= ovf_flag | (|fl_ovf);
    end

    assign acc_err  = err_v[ERR_ACC];
    assign acc_core = core_v[ERR_ACC];
    assign acc_addr = addr_v[ERR_ACC];
    assign ovl_err  = err_v[ERR_OVL];
    assign ovl_core = core_v[ERR_OVL];
    assign ovl_addr = addr_v[ERR_OVL];
    assign dat_err  = err_v[ERR_DAT];
    assign dat_core = core_v[ERR_DAT];
    assign dat_addr = addr_v[ERR_DAT];
endmodule

// File: rtl/coh_epoch_checker_sva.sv
// Port-level temporal properties of the epoch coherence monitor, bound to the top.
module coh_epoch_checker_sva #(
    parameter int NC = 4,
    parameter int AW = 16,
    localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NC-1:0] ev_valid,
    input logic          acc_err,
    input logic [CW-1:0] acc_core,
    input logic [AW-1:0] acc_addr,
    input logic          ovl_err,
    input logic [CW-1:0] ovl_core,
    input logic [AW-1:0] ovl_addr,
    input logic          dat_err,
    input logic [CW-1:0] dat_core,
    input logic [AW-1:0] dat_addr,
    input logic          ovf_flag
);
    p_sticky_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> acc_err && $stable(acc_core) && $stable(acc_addr));
    p_sticky_ovl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_err |=> ovl_err && $stable(ovl_core) && $stable(ovl_addr));
    p_sticky_dat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dat_err |=> dat_err && $stable(dat_core) && $stable(dat_addr));
    p_quiet_acc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid == '0 && !acc_err) |=> !acc_err);
    p_quiet_ovl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid == '0 && !ovl_err) |=> !ovl_err);
    p_quiet_dat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid == '0 && !dat_err) |=> !dat_err);
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid == '0 && !ovf_flag) |=> !ovf_flag);
    p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);
endmodule

bind coh_epoch_checker coh_epoch_checker_sva #(.NC(NC), .AW(AW)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_valid),
    .acc_err  (acc_err),
    .acc_core (acc_core),
    .acc_addr (acc_addr),
    .ovl_err  (ovl_err),
    .ovl_core (ovl_core),
    .ovl_addr (ovl_addr),
    .dat_err  (dat_err),
    .dat_core (dat_core),
    .dat_addr (dat_addr),
    .ovf_flag (ovf_flag)
);

// File: tb/coh_epoch_checker_test.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural reference model compared on every clock plus directed checks.
module coh_epoch_checker_test;
    localparam int NC = 4;
    localparam int NB = 8;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NC-1:0]        ev_valid = '0;
    logic [NC*3-1:0]      ev_kind = '0;
    logic [NC*AW-1:0]     ev_addr = '0;
    logic [NC*DW-1:0]     ev_data = '0;
    logic                 acc_err, ovl_err, dat_err, ovf_flag;
    logic [CW-1:0]        acc_core, ovl_core, dat_core;
    logic [AW-1:0]        acc_addr, ovl_addr, dat_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    coh_epoch_checker #(.NC(NC), .NB(NB), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_addr(ev_addr), .ev_data(ev_data),
        .acc_err(acc_err), .acc_core(acc_core), .acc_addr(acc_addr),
        .ovl_err(ovl_err), .ovl_core(ovl_core), .ovl_addr(ovl_addr),
        .dat_err(dat_err), .dat_core(dat_core), .dat_addr(dat_addr),
        .ovf_flag(ovf_flag)
    );

    // Reference model state
    bit          m_vld [NB];
    int unsigned m_tag [NB];
    bit          m_ro  [NB][NC];
    bit          m_rw  [NB][NC];
    int unsigned m_cval[NB];
    bit          m_ref [NB];
    int unsigned m_sval[NB];
    bit          m_sflg[NB];
    bit          me_err [3];
    int          me_core[3];
    int unsigned me_addr[3];
    bit          m_ovf;
    bit          pv[NC];
    int          pk[NC];
    int unsigned pa[NC];
    int unsigned pd[NC];

    task automatic chk(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit holds_any(int s);
        for (int c = 0; c < NC; c++) if (m_ro[s][c] || m_rw[s][c]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int find_slot(int unsigned a);
        for (int s = 0; s < NB; s++) if (m_vld[s] && m_tag[s] == a) return s;
        return -1;
    endfunction

    function automatic int find_free();
        for (int s = 0; s < NB; s++) if (!m_vld[s] || !holds_any(s)) return s;
        return -1;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NB; s++) begin
            m_vld[s] = 0; m_tag[s] = 0; m_cval[s] = 0; m_ref[s] = 0;
            m_sval[s] = 0; m_sflg[s] = 0;
            for (int c = 0; c < NC; c++) begin m_ro[s][c] = 0; m_rw[s][c] = 0; end
        end
        for (int g = 0; g < 3; g++) begin me_err[g] = 0; me_core[g] = 0; me_addr[g] = 0; end
        m_ovf = 0;
    endtask

    task automatic note(int g, int c, int unsigned a);
        if (!me_err[g]) begin me_err[g] = 1; me_core[g] = c; me_addr[g] = a; end
    endtask

    task automatic model_event(int c, int k, int unsigned a, int unsigned d);
        int s;
        s = find_slot(a);
        if (k == 0 || k == 1) begin
            if (s < 0) begin
                s = find_free();
                if (s < 0) begin m_ovf = 1; return; end
                m_vld[s] = 1; m_tag[s] = a; m_cval[s] = 0; m_ref[s] = 0;
                m_sval[s] = 0; m_sflg[s] = 0;
                for (int j = 0; j < NC; j++) begin m_ro[s][j] = 0; m_rw[s][j] = 0; end
            end
            if (m_ro[s][c] || m_rw[s][c]) begin note(0, c, a); return; end
            for (int j = 0; j < NC; j++)
                if (j != c && (m_rw[s][j] || (k == 1 && m_ro[s][j]))) begin note(1, c, a); break; end
            if (m_ref[s]) begin
                if (m_cval[s] != d) note(2, c, a);
            end else begin
                m_cval[s] = d; m_ref[s] = 1;
            end
            if (k == 1) begin m_rw[s][c] = 1; m_sflg[s] = 0; end
            else m_ro[s][c] = 1;
        end else if (k == 2) begin
            if (s < 0) note(0, c, a);
            else if (m_rw[s][c]) begin
                if (m_sflg[s]) m_cval[s] = m_sval[s];
                m_sflg[s] = 0; m_rw[s][c] = 0;
            end else if (m_ro[s][c]) m_ro[s][c] = 0;
            else note(0, c, a);
        end else if (k == 3) begin
            if (s < 0 || !(m_ro[s][c] || m_rw[s][c])) note(0, c, a);
        end else if (k == 4) begin
            if (s < 0 || !m_rw[s][c]) note(0, c, a);
            else begin m_sval[s] = d; m_sflg[s] = 1; end
        end
    endtask

    task automatic compare_all();
        chk("R1 acc_err", acc_err, me_err[0]);
        chk("R8 acc_core", acc_core, me_core[0]);
        chk("R8 acc_addr", acc_addr, me_addr[0]);
        chk("R3 ovl_err", ovl_err, me_err[1]);
        chk("R8 ovl_core", ovl_core, me_core[1]);
        chk("R8 ovl_addr", ovl_addr, me_addr[1]);
        chk("R4 dat_err", dat_err, me_err[2]);
        chk("R8 dat_core", dat_core, me_core[2]);
        chk("R8 dat_addr", dat_addr, me_addr[2]);
        chk("R9 ovf_flag", ovf_flag, m_ovf);
    endtask

    task automatic set_ev(int c, int k, int unsigned a, int unsigned d);
        pv[c] = 1; pk[c] = k; pa[c] = a; pd[c] = d;
        ev_valid[c] = 1'b1;
        ev_kind[c*3 +: 3] = 3'(k);
        ev_addr[c*AW +: AW] = AW'(a);
        ev_data[c*DW +: DW] = DW'(d);
    endtask

    task automatic clr_ev();
        for (int c = 0; c < NC; c++) pv[c] = 0;
        ev_valid = '0; ev_kind = '0; ev_addr = '0; ev_data = '0;
    endtask

    task automatic tick();
        for (int c = 0; c < NC; c++) if (pv[c]) model_event(c, pk[c], pa[c], pd[c]);
        @(posedge clk);
        @(negedge clk);
        compare_all();
        clr_ev();
    endtask

    task automatic one(int c, int k, int unsigned a, int unsigned d);
        set_ev(c, k, a, d);
        tick();
    endtask

    task automatic do_reset();
        clr_ev();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        compare_all();
    endtask

    initial begin : watchdog
        #1600000;
        n_fail++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin : main
        clr_ev();
        model_reset();
        do_reset();
        // R10: reset state
        chk("R10 flags after reset", {acc_err, ovl_err, dat_err, ovf_flag}, 0);
        chk("R10 latched after reset", {acc_core, acc_addr, ovl_core, ovl_addr, dat_core, dat_addr}, 0);

        // R1: load outside and inside an interval
        one(1, 0, 'h10, 5); one(1, 3, 'h10, 5);
        chk("R1 legal load", acc_err, 0);
        one(0, 3, 'h10, 5);
        chk("R1 illegal load flag", acc_err, 1);
        chk("R1 illegal load core", acc_core, 0);

        // R2: store in read-only vs read-write interval
        do_reset();
        one(2, 1, 'h20, 0); one(2, 4, 'h20, 7);
        chk("R2 store in rw", acc_err, 0);
        one(3, 0, 'h30, 0); one(3, 4, 'h30, 7);
        chk("R2 store in ro flag", acc_err, 1);
        chk("R2 store in ro core", acc_core, 3);

        // R3: overlap rules
        do_reset();
        one(0, 0, 'h40, 7); one(1, 0, 'h40, 7);
        chk("R3 two readers ok", ovl_err, 0);
        one(2, 1, 'h40, 7);
        chk("R3 writer over readers", ovl_err, 1);
        chk("R3 writer over readers core", ovl_core, 2);
        do_reset();
        one(0, 1, 'h41, 7); one(1, 0, 'h41, 7);
        chk("R3 reader over writer core", {ovl_err, 2'(ovl_core)}, {1'b1, 2'd1});

        // R4: committed value carried across intervals
        do_reset();
        one(0, 1, 'h50, 3); one(0, 4, 'h50, 9); one(0, 4, 'h50, 11); one(0, 2, 'h50, 0);
        one(1, 0, 'h50, 11);
        chk("R4 last store committed", dat_err, 0);
        one(1, 2, 'h50, 0); one(3, 1, 'h50, 11); one(3, 2, 'h50, 0);
        one(0, 0, 'h50, 11);
        chk("R4 no-store rw keeps value", dat_err, 0);
        one(2, 0, 'h50, 9);
        chk("R4 stale value flag", dat_err, 1);
        chk("R4 stale value where", {2'(dat_core), 16'(dat_addr)}, {2'd2, 16'h50});

        // R5: first open sets the reference
        do_reset();
        one(1, 0, 'h55, 'h77); one(1, 2, 'h55, 0); one(2, 0, 'h55, 'h77);
        chk("R5 reference taken", dat_err, 0);
        one(3, 0, 'h55, 'h12);
        chk("R5 mismatch vs reference core", {dat_err, 2'(dat_core)}, {1'b1, 2'd3});

        // R6: stray close and double open
        do_reset();
        one(0, 2, 'h60, 0);
        chk("R6 close untracked", {acc_err, 16'(acc_addr)}, {1'b1, 16'h60});
        do_reset();
        one(1, 0, 'h61, 0); one(1, 1, 'h61, 0);
        chk("R6 double open", {acc_err, 2'(acc_core), ovl_err}, {1'b1, 2'd1, 1'b0});

        // R7: same-cycle ordering by core index
        do_reset();
        one(0, 1, 'h70, 0); one(0, 4, 'h70, 5);
        set_ev(0, 2, 'h70, 0); set_ev(1, 0, 'h70, 5); tick();
        chk("R7 close before open is clean", {ovl_err, dat_err}, 0);
        do_reset();
        one(1, 1, 'h71, 0);
        set_ev(0, 0, 'h71, 0); set_ev(1, 2, 'h71, 0); tick();
        chk("R7 open before close overlaps", {ovl_err, 2'(ovl_core)}, {1'b1, 2'd0});

        // R8: lowest core wins, then held
        do_reset();
        set_ev(2, 3, 'h22, 0); set_ev(1, 3, 'h11, 0); tick();
        one(3, 3, 'h33, 0);
        chk("R8 first and lowest kept", {2'(acc_core), 16'(acc_addr)}, {2'd1, 16'h11});

        // R9: fill, overflow, release and reuse
        do_reset();
        for (int i = 0; i < NB; i++) one(0, 0, 'h100 + i, 0);
        chk("R9 full table no overflow yet", ovf_flag, 0);
        one(1, 0, 'h200, 0);
        chk("R9 overflow raised", {ovf_flag, ovl_err, acc_err}, {1'b1, 1'b0, 1'b0});
        one(0, 2, 'h103, 0); one(1, 1, 'h200, 4); one(2, 0, 'h200, 4);
        chk("R9 reuse of idle entry", {ovl_err, 2'(ovl_core)}, {1'b1, 2'd2});
        one(3, 3, 'h103, 0);
        chk("R9 evicted block untracked", {acc_err, 16'(acc_addr)}, {1'b1, 16'h103});

        // Pseudo-random streams checked against the model every cycle
        for (int r = 0; r < 30; r++) begin
            do_reset();
            for (int n = 0; n < 60; n++) begin
                for (int c = 0; c < NC; c++)
                    if ($urandom_range(1, 0) == 1)
                        set_ev(c, $urandom_range(4, 0), $urandom_range(NB + 1, 0),
                               $urandom_range(3, 0));
                tick();
            end
        end

        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end
endmodule